// File: doc/BRIEF.md
# Virtualized Register Access Decoder

This block is the front end for register accesses into a device that presents several virtual copies of one register set in a single address window. The low byte of an access address picks a register, and the bits above it pick the virtual interface. Each access is checked before anything downstream sees it. The register must exist at that offset, its width must match the access size, the direction must be allowed, and the interface index must lie inside the configured count. A legal access leaves the block one cycle later as a register identifier plus an interface index. An illegal access comes out as a one-cycle error pulse and has no other effect.

The block holds only two pieces of state: the shared configuration word and the sticky interrupt status, which a read clears. Every other register lives in a neighbouring register file. That file receives the decoded access, and for reads it returns its data on `ext_rdata` during the response cycle. A static strap sets the number of virtual interfaces. The block raises a strap of zero to one and limits a strap above `MAX_VIF` to `MAX_VIF`.

Top module: `virt_reg_decoder`

## Requirements
- R1: The register offset is address bits [7:0] and the interface index is the address bits above bit 7. A legal access reports that index on `acc_vif`.
- R2: Offsets 0x00 to 0x2C, in steps of 4, are 32-bit registers with identifiers 0 to 11 (offset/4). Offsets 0x30 to 0x60, in steps of 8, are 64-bit registers with identifiers 12 to 18 (12 + (offset-0x30)/8). The identifier appears on `acc_reg`.
- R3: An offset of 0x68 or above, or an offset that is not aligned to its register's width, is an error.
- R4: `req_size` gives the access size in bytes. Any size other than 4 for a 32-bit register, or 8 for a 64-bit register, is an error.
- R5: Identifiers 1, 12 and 15 are write-only. Identifiers 0 and 3 are read-write. All other identifiers are read-only. An access in a forbidden direction is an error.
- R6: The effective interface count is 1 when the strap is 0, `MAX_VIF` when the strap exceeds `MAX_VIF`, and the strap value otherwise. An interface index at or above the effective count is an error.
- R7: An erroneous access sets `acc_err` together with `acc_valid` and returns zero read data. It changes neither the configuration word nor the interrupt status.
- R8: Every request produces exactly one `acc_valid` pulse, one cycle later.
- R9: Each bit of the interrupt status is set by a pulse on `intr_set` and stays set until the status register (identifier 2) is read. The read returns the status and clears it. Events that arrive in the same cycle as the read remain set afterwards.
- R10: The configuration word (identifier 0) is read-write. Bit 12 drives `cfg_zero_copy`, bit 11 drives `cfg_delay_copy`, bit 10 drives `cfg_rss` and bit 5 drives `cfg_vaddr`. A write that sets bits 12 and 11 together is an error and is discarded.
- R11: Reads of identifiers 0, 2 and 7 return, zero-extended, the configuration word, the interrupt status and the effective interface count. Reads of any other readable register return `ext_rdata` during the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Access address (interface index and offset) |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| vif_count | input | ADDR_W-7 | Strap for the number of virtual interfaces |
| intr_set | input | INTR_W | Interrupt event pulses |
| ext_rdata | input | 64 | Read data from the neighbouring register file |
| acc_valid | output | 1 | Response strobe, one per request |
| acc_err | output | 1 | Request was rejected |
| acc_write | output | 1 | Direction of the accepted access |
| acc_reg | output | 5 | Register identifier |
| acc_vif | output | ADDR_W-8 | Interface index |
| acc_wdata | output | 64 | Write data forwarded |
| acc_rdata | output | 64 | Read data |
| cfg_word | output | 32 | Configuration word |
| cfg_zero_copy | output | 1 | Zero-copy enable |
| cfg_delay_copy | output | 1 | Delayed-copy enable |
| cfg_rss | output | 1 | Receive-side scaling enable |
| cfg_vaddr | output | 1 | Virtual addressing enable |
| intr_status | output | INTR_W | Interrupt status |

## Verification
The bench builds the block with a 12-bit address, so four bits index interfaces, with `MAX_VIF` of 4 and a reset configuration that has bit 5 set. With these values, indices 4 to 15 lie above the cap and can be reached. The bench drives the strap to 3, to 0 and to 9, which covers the plain count, the raise to one and the limit. The non-zero reset value also makes the reset decoding of the configuration outputs visible.

// File: rtl/vrd_pkg.sv
package vrd_pkg;

    localparam int        REG_ID_W     = 5;
    localparam logic [7:0] WIDE_BASE   = 8'h30;
    localparam logic [7:0] WIDE_SPAN   = 8'h38;
    localparam int        FIRST_WIDE   = 12;
    localparam int        CFG_ZCOPY_B  = 12;
    localparam int        CFG_DCOPY_B  = 11;
    localparam int        CFG_RSS_B    = 10;
    localparam int        CFG_VADDR_B  = 5;

    typedef enum logic [REG_ID_W-1:0] {
        RG_CONFIG    = 5'd0,
        RG_COMMAND   = 5'd1,
        RG_INTR_STAT = 5'd2,
        RG_INTR_MASK = 5'd3,
        RG_RX_MAXCPY = 5'd4,
        RG_TX_MAXCPY = 5'd5,
        RG_RX_MAXINT = 5'd6,
        RG_VCOUNT    = 5'd7,
        RG_RX_FSIZE  = 5'd8,
        RG_TX_FSIZE  = 5'd9,
        RG_RX_MARK   = 5'd10,
        RG_TX_MARK   = 5'd11,
        RG_RX_DATA   = 5'd12,
        RG_RX_DONE   = 5'd13,
        RG_RX_WAIT   = 5'd14,
        RG_TX_DATA   = 5'd15,
        RG_TX_DONE   = 5'd16,
        RG_TX_WAIT   = 5'd17,
        RG_HWADDR    = 5'd18
    } reg_id_e;

    function automatic logic reg_readable(reg_id_e id);
        case (id)
            RG_COMMAND, RG_RX_DATA, RG_TX_DATA: return 1'b0;
            default:                            return 1'b1;
        endcase
    endfunction

    function automatic logic reg_writable(reg_id_e id);
        case (id)
            RG_CONFIG, RG_COMMAND, RG_INTR_MASK,
            RG_RX_DATA, RG_TX_DATA:             return 1'b1;
            default:                            return 1'b0;
        endcase
    endfunction

    function automatic logic reg_held_here(reg_id_e id);
        case (id)
            RG_CONFIG, RG_INTR_STAT, RG_VCOUNT: return 1'b1;
            default:                            return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/vrd_decode.sv
module vrd_decode
    import vrd_pkg::*;
(
    input  logic [7:0] offset,
    output logic       off_ok,
    output reg_id_e    reg_id,
    output logic       wide
);

    logic [7:0] rel;
    assign rel = offset - WIDE_BASE;

    // Narrow window: id = offset/4; wide window: id = 12 + rel/8.
    always_comb begin
        if (offset < WIDE_BASE) begin
            off_ok = (offset[1:0] == 2'b00);
            reg_id = reg_id_e'({1'b0, offset[5:2]});
            wide   = 1'b0;
        end else if (rel < WIDE_SPAN) begin
            off_ok = (rel[2:0] == 3'b000);
            reg_id = reg_id_e'(5'(FIRST_WIDE) + {2'b00, rel[5:3]});
            wide   = 1'b1;
        end else begin
            off_ok = 1'b0;
            reg_id = RG_CONFIG;
            wide   = 1'b0;
        end
    end

endmodule

// File: rtl/vrd_vif_check.sv
module vrd_vif_check #(
    parameter int VIF_W   = 8,
    parameter int MAX_VIF = 4
) (
    input  logic [VIF_W-1:0] vif,
    input  logic [VIF_W:0]   count_strap,
    output logic [VIF_W:0]   eff_count,
    output logic             in_range
);

    localparam int              CNT_W = VIF_W + 1;
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(MAX_VIF);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    always_comb begin
        if (count_strap == '0)
            eff_count = ONE;
        else if (count_strap > CAP)
            eff_count = CAP;
        else
            eff_count = count_strap;
    end

    assign in_range = ({1'b0, vif} < eff_count);

endmodule

// File: rtl/vrd_state.sv
module vrd_state
    import vrd_pkg::*;
#(
    parameter int          INTR_W    = 9,
    parameter logic [31:0] CFG_RESET = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              intr_clr,
    input  logic [INTR_W-1:0] intr_set,
    output logic [31:0]       cfg_q,
    output logic [INTR_W-1:0] intr_q
);

    typedef struct packed {
        logic [31:0]       cfg;
        logic [INTR_W-1:0] intr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we)
            st_d.cfg = cfg_wdata;
        // Clear on read, but events of this cycle survive the clear.
        st_d.intr = (intr_clr ? '0 : st_q.intr) | intr_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg  <= CFG_RESET;
            st_q.intr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q  = st_q.cfg;
    assign intr_q = st_q.intr;

    // R10: the two copy modes are never enabled together
    a_r10_copy_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_q[CFG_ZCOPY_B] && cfg_q[CFG_DCOPY_B]));

    // R9: after a clearing read only the same-cycle events remain
    a_r9_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        intr_clr |=> (intr_q == $past(intr_set)));

    // R9: without a read no status bit drops
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !intr_clr |=> ((intr_q & $past(intr_q)) == $past(intr_q)));

endmodule

// File: rtl/virt_reg_decoder.sv
module virt_reg_decoder
    import vrd_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          MAX_VIF   = 4,
    parameter int          INTR_W    = 9,
    parameter logic [31:0] CFG_RESET = 32'h0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [3:0]          req_size,
    input  logic [63:0]         req_wdata,
    input  logic [ADDR_W-8:0]   vif_count,
    input  logic [INTR_W-1:0]   intr_set,
    input  logic [63:0]         ext_rdata,
    output logic                acc_valid,
    output logic                acc_err,
    output logic                acc_write,
    output logic [4:0]          acc_reg,
    output logic [ADDR_W-9:0]   acc_vif,
    output logic [63:0]         acc_wdata,
    output logic [63:0]         acc_rdata,
    output logic [31:0]         cfg_word,
    output logic                cfg_zero_copy,
    output logic                cfg_delay_copy,
    output logic                cfg_rss,
    output logic                cfg_vaddr,
    output logic [INTR_W-1:0]   intr_status
);

    localparam int VIF_W = ADDR_W - 8;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic              write;
        reg_id_e           id;
        logic [VIF_W-1:0]  vif;
        logic [63:0]       wdata;
        logic [63:0]       rdata;
        logic              ext;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [7:0]       offset;
    logic [VIF_W-1:0] vif;
    logic             off_ok;
    reg_id_e          reg_id;
    logic             wide;
    logic [VIF_W:0]   eff_count;
    logic             vif_ok;
    logic             size_ok;
    logic             dir_ok;
    logic             cfg_clash;
    logic             legal;
    logic             cfg_we;
    logic             intr_clr;
    logic [31:0]      cfg_q;
    logic [INTR_W-1:0] intr_q;
    logic [63:0]      local_rdata;

    assign offset = req_addr[7:0];
    assign vif    = req_addr[ADDR_W-1:8];

    vrd_decode u_decode (
        .offset (offset),
        .off_ok (off_ok),
        .reg_id (reg_id),
        .wide   (wide)
    );

    vrd_vif_check #(
        .VIF_W   (VIF_W),
        .MAX_VIF (MAX_VIF)
    ) u_vif (
        .vif         (vif),
        .count_strap (vif_count),
        .eff_count   (eff_count),
        .in_range    (vif_ok)
    );

    always_comb begin
        size_ok   = wide ? (req_size == 4'd8) : (req_size == 4'd4);
        dir_ok    = req_write ? reg_writable(reg_id) : reg_readable(reg_id);
        cfg_clash = req_write && (reg_id == RG_CONFIG) &&
                    req_wdata[CFG_ZCOPY_B] && req_wdata[CFG_DCOPY_B];
        legal     = off_ok && size_ok && dir_ok && vif_ok && !cfg_clash;
        cfg_we    = req_valid && legal && req_write && (reg_id == RG_CONFIG);
        intr_clr  = req_valid && legal && !req_write && (reg_id == RG_INTR_STAT);
    end

    vrd_state #(
        .INTR_W    (INTR_W),
        .CFG_RESET (CFG_RESET)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (req_wdata[31:0]),
        .intr_clr  (intr_clr),
        .intr_set  (intr_set),
        .cfg_q     (cfg_q),
        .intr_q    (intr_q)
    );

    always_comb begin
        case (reg_id)
            RG_CONFIG:    local_rdata = {32'h0, cfg_q};
            RG_INTR_STAT: local_rdata = 64'(intr_q);
            RG_VCOUNT:    local_rdata = 64'(eff_count);
            default:      local_rdata = 64'h0;
        endcase
    end

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (legal) begin
                rsp_d.write = req_write;
                rsp_d.id    = reg_id;
                rsp_d.vif   = vif;
                rsp_d.wdata = req_write ? req_wdata : 64'h0;
                if (!req_write) begin
                    rsp_d.ext   = !reg_held_here(reg_id);
                    rsp_d.rdata = local_rdata;
                end
            end else begin
                rsp_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    assign acc_valid      = rsp_q.valid;
    assign acc_err        = rsp_q.err;
    assign acc_write      = rsp_q.write;
    assign acc_reg        = rsp_q.id;
    assign acc_vif        = rsp_q.vif;
    assign acc_wdata      = rsp_q.wdata;
    assign acc_rdata      = (rsp_q.valid && rsp_q.ext) ? ext_rdata : rsp_q.rdata;
    assign cfg_word       = cfg_q;
    assign cfg_zero_copy  = cfg_q[CFG_ZCOPY_B];
    assign cfg_delay_copy = cfg_q[CFG_DCOPY_B];
    assign cfg_rss        = cfg_q[CFG_RSS_B];
    assign cfg_vaddr      = cfg_q[CFG_VADDR_B];
    assign intr_status    = intr_q;

    // R8: each request is answered in the next cycle
    a_r8_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> acc_valid);

    // R8: no response without a request
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !acc_valid);

    // R7: a rejected access returns zero data
    a_r7_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (acc_valid && acc_rdata == 64'h0));

    // R7: a rejected access leaves the configuration alone
    a_r7_err_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $stable(cfg_word));

    // R6: an accepted access targets an existing interface
    a_r6_vif_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_err) |-> ({1'b0, acc_vif} < eff_count));

endmodule

// File: tb/virt_reg_decoder_tb.sv
`timescale 1ns/1ps
module virt_reg_decoder_tb_top;

    localparam int          ADDR_W    = 12;
    localparam int          VIF_W     = ADDR_W - 8;
    localparam int          MAX_VIF   = 4;
    localparam int          INTR_W    = 9;
    localparam logic [31:0] CFG_RESET = 32'h0000_0020;
    localparam logic [63:0] EXT_WORD  = 64'hC0DE_0000_F00D_0042;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_write = 1'b0;
    logic [ADDR_W-1:0]   req_addr = '0;
    logic [3:0]          req_size = '0;
    logic [63:0]         req_wdata = '0;
    logic [VIF_W:0]      vif_count = 5'd3;
    logic [INTR_W-1:0]   intr_set = '0;
    logic [63:0]         ext_rdata = EXT_WORD;
    logic                acc_valid, acc_err, acc_write;
    logic [4:0]          acc_reg;
    logic [VIF_W-1:0]    acc_vif;
    logic [63:0]         acc_wdata, acc_rdata;
    logic [31:0]         cfg_word;
    logic                cfg_zero_copy, cfg_delay_copy, cfg_rss, cfg_vaddr;
    logic [INTR_W-1:0]   intr_status;

    always #2.5 clk = ~clk;

    virt_reg_decoder #(
        .ADDR_W    (ADDR_W),
        .MAX_VIF   (MAX_VIF),
        .INTR_W    (INTR_W),
        .CFG_RESET (CFG_RESET)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_size (req_size), .req_wdata (req_wdata), .vif_count (vif_count),
        .intr_set (intr_set), .ext_rdata (ext_rdata),
        .acc_valid (acc_valid), .acc_err (acc_err), .acc_write (acc_write),
        .acc_reg (acc_reg), .acc_vif (acc_vif), .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata), .cfg_word (cfg_word),
        .cfg_zero_copy (cfg_zero_copy), .cfg_delay_copy (cfg_delay_copy),
        .cfg_rss (cfg_rss), .cfg_vaddr (cfg_vaddr), .intr_status (intr_status)
    );

    typedef struct {
        bit          err;
        int          id;
        int          vif;
        bit          wr;
        logic [63:0] wd;
        logic [63:0] rd;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          n_issued = 0;
    int          n_resp = 0;
    bit          done = 1'b0;
    logic [31:0] m_cfg = CFG_RESET;
    logic [INTR_W-1:0] m_intr = '0;

    function automatic int eff_cnt();
        if (vif_count == 0) return 1;
        if (int'(vif_count) > MAX_VIF) return MAX_VIF;
        return int'(vif_count);
    endfunction

    function automatic bit may_read(int id);
        return !(id == 1 || id == 12 || id == 15);
    endfunction

    function automatic bit may_write(int id);
        return (id == 0 || id == 1 || id == 3 || id == 12 || id == 15);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: one request, expected response pushed to the scoreboard.
    task automatic access(string tag, bit wr, logic [ADDR_W-1:0] addr, int sz,
                          logic [63:0] wd, logic [INTR_W-1:0] setv);
        exp_t e;
        int   off;
        int   w;
        @(negedge clk);
        off   = int'(addr[7:0]);
        e.vif = int'(addr[ADDR_W-1:8]);
        e.wr  = wr;
        e.wd  = wd;
        e.tag = tag;
        e.id  = -1;
        w     = 0;
        if (off < 48 && off % 4 == 0) begin
            e.id = off / 4; w = 4;
        end else if (off >= 48 && off < 104 && off % 8 == 0) begin
            e.id = 12 + (off - 48) / 8; w = 8;
        end
        e.err = (e.id < 0) || (sz != w) ||
                (wr ? !may_write(e.id) : !may_read(e.id)) ||
                (e.vif >= eff_cnt()) ||
                (wr && e.id == 0 && wd[12] && wd[11]);
        e.rd = 64'h0;
        if (!e.err && !wr) begin
            case (e.id)
                0:       e.rd = {32'h0, m_cfg};
                2:       e.rd = 64'(m_intr);
                7:       e.rd = 64'(eff_cnt());
                default: e.rd = EXT_WORD;
            endcase
        end
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_size  = 4'(sz);
        req_wdata = wd;
        intr_set  = setv;
        if (!e.err && wr && e.id == 0) m_cfg = wd[31:0];
        if (!e.err && !wr && e.id == 2) m_intr = setv;
        else m_intr = m_intr | setv;
        sb_q.push_back(e);
        n_issued++;
        @(negedge clk);
        req_valid = 1'b0;
        intr_set  = '0;
    endtask

    task automatic pulse(logic [INTR_W-1:0] setv);
        @(negedge clk);
        intr_set = setv;
        m_intr   = m_intr | setv;
        @(negedge clk);
        intr_set = '0;
    endtask

    // Monitor: compares each response against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && acc_valid) begin
            n_resp++;
            if (sb_q.size() == 0) begin
                chk(1'b0, "R8", "response with no request", 64'(acc_reg), 64'h0);
            end else begin
                exp_t e;
                bit   ok;
                e  = sb_q.pop_front();
                ok = (acc_err == e.err);
                if (e.err)
                    ok = ok && (acc_rdata == 64'h0);
                else
                    ok = ok && (int'(acc_reg) == e.id) && (int'(acc_vif) == e.vif) &&
                         (acc_write == e.wr) &&
                         (e.wr ? (acc_wdata == e.wd) : (acc_rdata == e.rd));
                chk(ok, e.tag,
                    $sformatf("err=%0b/%0b reg=%0d/%0d vif=%0d/%0d data",
                              acc_err, e.err, acc_reg, e.id, acc_vif, e.vif),
                    e.wr ? acc_wdata : acc_rdata, e.wr ? e.wd : e.rd);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R8 watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(acc_valid == 1'b0, "R8", "valid after reset", 64'(acc_valid), 64'h0);
        chk(intr_status == '0, "R9", "status after reset", 64'(intr_status), 64'h0);
        chk(cfg_word == CFG_RESET, "R10", "cfg after reset", 64'(cfg_word), 64'(CFG_RESET));
        chk(cfg_vaddr == 1'b1, "R10", "vaddr after reset", 64'(cfg_vaddr), 64'h1);

        // R1 R2 R11: decode and pass-through data
        access("R2 rx max copy",   1'b0, 12'h010, 4, 64'h0, '0);
        access("R1 hwaddr vif2",   1'b0, 12'h260, 8, 64'h0, '0);
        access("R2 tx done vif1",  1'b0, 12'h150, 8, 64'h0, '0);
        access("R2 command write", 1'b1, 12'h104, 4, 64'h0000_0000_1234_5678, '0);
        access("R11 count read",   1'b0, 12'h01C, 4, 64'h0, '0);
        access("R2 tx data write", 1'b1, 12'h248, 8, 64'hFEED_0001_0000_BEEF, '0);
        access("R2 tx mark read",  1'b0, 12'h02C, 4, 64'h0, '0);

        // R3: bad offsets
        access("R3 past end",      1'b0, 12'h068, 8, 64'h0, '0);
        access("R3 wide misalign", 1'b0, 12'h034, 8, 64'h0, '0);
        access("R3 top offset",    1'b0, 12'h0FF, 4, 64'h0, '0);
        access("R3 narrow misal",  1'b0, 12'h006, 4, 64'h0, '0);

        // R4: size mismatch
        access("R4 cfg as 8",      1'b0, 12'h000, 8, 64'h0, '0);
        access("R4 rx done as 4",  1'b0, 12'h038, 4, 64'h0, '0);

        // R5: direction
        access("R5 read command",  1'b0, 12'h004, 4, 64'h0, '0);
        access("R5 write ro",      1'b1, 12'h010, 4, 64'h5, '0);
        access("R5 write status",  1'b1, 12'h008, 4, 64'h1FF, '0);
        access("R5 read rx data",  1'b0, 12'h030, 8, 64'h0, '0);
        access("R5 mask rw",       1'b1, 12'h00C, 4, 64'h3, '0);

        // R6: interface count
        access("R6 vif at count",  1'b0, 12'h310, 4, 64'h0, '0);
        @(negedge clk); vif_count = 5'd0; @(negedge clk);
        access("R6 zero strap v1", 1'b0, 12'h110, 4, 64'h0, '0);
        access("R6 zero strap v0", 1'b0, 12'h010, 4, 64'h0, '0);
        access("R11 count forced", 1'b0, 12'h01C, 4, 64'h0, '0);
        @(negedge clk); vif_count = 5'd9; @(negedge clk);
        access("R6 capped v3",     1'b0, 12'h310, 4, 64'h0, '0);
        access("R6 capped v4",     1'b0, 12'h410, 4, 64'h0, '0);
        access("R6 capped v15",    1'b0, 12'hF10, 4, 64'h0, '0);
        access("R11 count capped", 1'b0, 12'h01C, 4, 64'h0, '0);

        // R10: configuration
        access("R10 cfg write",    1'b1, 12'h000, 4, 64'h0000_1420, '0);
        chk(cfg_zero_copy == 1'b1 && cfg_rss == 1'b1 && cfg_vaddr == 1'b1 && cfg_delay_copy == 1'b0,
            "R10", "decoded bits", {60'h0, cfg_zero_copy, cfg_delay_copy, cfg_rss, cfg_vaddr}, 64'hB);
        access("R10 cfg read",     1'b0, 12'h000, 4, 64'h0, '0);
        access("R10 clash write",  1'b1, 12'h000, 4, 64'h0000_1800, '0);
        chk(cfg_word == 32'h0000_1420, "R7", "cfg kept after error", 64'(cfg_word), 64'h1420);
        access("R10 cfg reread",   1'b0, 12'h100, 4, 64'h0, '0);
        access("R10 delay write",  1'b1, 12'h000, 4, 64'h0000_0800, '0);
        chk(cfg_delay_copy == 1'b1 && cfg_zero_copy == 1'b0, "R10", "delay copy",
            {62'h0, cfg_delay_copy, cfg_zero_copy}, 64'h2);

        // R9: interrupt status
        pulse(9'h005);
        chk(intr_status == 9'h005, "R9", "sticky set", 64'(intr_status), 64'h5);
        access("R7 status bad size", 1'b0, 12'h008, 8, 64'h0, '0);
        chk(intr_status == 9'h005, "R7", "status kept after error", 64'(intr_status), 64'h5);
        access("R9 status read",   1'b0, 12'h008, 4, 64'h0, '0);
        chk(intr_status == 9'h000, "R9", "cleared by read", 64'(intr_status), 64'h0);
        pulse(9'h0A0);
        access("R9 read with set", 1'b0, 12'h208, 4, 64'h0, 9'h100);
        chk(intr_status == 9'h100, "R9", "same-cycle set kept", 64'(intr_status), 64'h100);
        access("R9 read again",    1'b0, 12'h008, 4, 64'h0, '0);

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R8", "pending expectations", 64'(sb_q.size()), 64'h0);
        chk(n_resp == n_issued, "R8", "responses vs requests", 64'(n_resp), 64'(n_issued));
        finish_run();
    end

endmodule